// File: doc/BRIEF.md
# Boot Firmware ROM Controller

This block answers processor read requests aimed at the boot firmware flash. Any request whose address falls in the 16 MiB firmware window (FD000000h to FDFFFFFFh) is claimed. The block then drives the flash read port with the window offset and holds output enable for a programmable number of clocks. After that it returns the sampled flash word with a one-cycle acknowledge.

A remap control bit mirrors the start of the firmware into the lowest 1 MiB of the address space, so the processor can fetch its reset vectors from address zero. The bit is set out of reset. Software clears it once it has copied what it needs out of the low region. A remapped access uses its low 20 address bits as the offset from the window start.

A small configuration port exposes two byte registers. Address 0 is flash configuration: bit 7 enables the controller, bits 2:0 set the access latency, and the other bits are reserved. Address 1 is remap control, with the remap bit in bit 1. While the controller is disabled, claimed requests end with an error response.

Top module: `boot_rom_ctrl`

## Requirements
- R1: After reset, configuration address 0 reads 80h (enabled, latency field 0) and configuration address 1 reads 02h (remap active).
- R2: Configuration address 0 keeps only bits 7 and 2:0 (bits 6:3 read zero whatever is written), and configuration address 1 keeps only bit 1 (all other bits read zero).
- R3: A request to FD000000h–FDFFFFFFh is claimed and presents address bits 23:0 on flash_addr_o, held stable while flash_oe_o is high.
- R4: With the remap bit set, a request to 00000000h–000FFFFFh is claimed and presents {4'h0, addr[19:0]} on flash_addr_o.
- R5: With the remap bit clear, a request to the low 1 MiB gets no ack_o, no err_o and no flash_oe_o.
- R6: With the controller enabled and latency field L in 1..7, flash_oe_o is high for exactly L cycles after the accepting edge, and ack_o is high in the cycle right after the last of them.
- R7: A latency field of 0 gives 8 cycles of flash_oe_o before ack_o.
- R8: With enable bit 7 clear, a claimed request gets ack_o and err_o together in the cycle after the accepting edge, and flash_oe_o stays low.
- R9: ack_o is a single-cycle pulse. On a successful ack, rdata_o equals the flash word present in the last cycle of output enable.
- R10: A request outside both claimed regions is never answered and never starts a flash read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU read request, held until ack_o |
| addr_i | input | 32 | CPU byte address |
| ack_o | output | 1 | Access complete (one cycle) |
| err_o | output | 1 | Error response, valid with ack_o |
| rdata_o | output | 16 | Read data, valid with ack_o |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | Configuration register select |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data |
| flash_addr_o | output | 24 | Flash word offset |
| flash_oe_o | output | 1 | Flash output enable |
| flash_data_i | input | 16 | Flash read data |

## Verification
The assertions check the properties that hold on every cycle: ack_o lasts one cycle, err_o appears only with ack_o and never together with output enable, and the flash address stays stable across an output-enable run. They also check that such a run never exceeds eight cycles and that a successful ack always follows output enable. The exact latency for each field value, the two decode regions and their offsets, the effect of the remap bit, the masking of reserved bits and the reset values all depend on the configuration and the address. Only the bench's scenarios can show these.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned LAT_W = 3;
  localparam int unsigned CNT_W = LAT_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } brc_state_e;

  // field value 0 encodes the longest wait
  function automatic logic [CNT_W-1:0] lat_cycles(logic [LAT_W-1:0] f);
    if (f == '0) lat_cycles = CNT_W'(1 << LAT_W);
    else         lat_cycles = CNT_W'(f);
  endfunction
endpackage

// File: rtl/brc_decode.sv
module brc_decode #(
  parameter int unsigned          AW        = 32,
  parameter int unsigned          WIN_BITS  = 24,
  parameter int unsigned          MAP_BITS  = 20,
  parameter logic [AW-1:0]        WIN_BASE  = 32'hFD00_0000
) (
  input  logic [AW-1:0]       addr_i,
  input  logic                remap_i,
  output logic                hit_o,
  output logic [WIN_BITS-1:0] offset_o
);
  logic win_hit, low_hit;

  assign win_hit = (addr_i[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);
  assign low_hit = remap_i && (addr_i[AW-1:MAP_BITS] == '0);
  assign hit_o   = win_hit || low_hit;

  always_comb begin
    if (win_hit) offset_o = addr_i[WIN_BITS-1:0];
    else         offset_o = {{(WIN_BITS-MAP_BITS){1'b0}}, addr_i[MAP_BITS-1:0]};
  end
endmodule

// File: rtl/brc_cfg.sv
module brc_cfg
  import brc_pkg::*;
#(
  parameter logic [7:0] FCFG_RST  = 8'h80,
  parameter logic [7:0] FCFG_MASK = 8'h87,
  parameter logic [7:0] RMAP_RST  = 8'h02,
  parameter logic [7:0] RMAP_MASK = 8'h02,
  parameter int unsigned EN_BIT   = 7,
  parameter int unsigned RMAP_BIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             en_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             remap_o
);
  logic [7:0] fcfg_q, rmap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcfg_q <= FCFG_RST;
      rmap_q <= RMAP_RST;
    end else if (we_i) begin
      if (!sel_i) fcfg_q <= wdata_i & FCFG_MASK;
      else        rmap_q <= wdata_i & RMAP_MASK;
    end
  end

  assign rdata_o = sel_i ? rmap_q : fcfg_q;
  assign en_o    = fcfg_q[EN_BIT];
  assign lat_o   = fcfg_q[LAT_W-1:0];
  assign remap_o = rmap_q[RMAP_BIT];
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int unsigned WIN_BITS = 24,
  parameter int unsigned DW       = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                hit_i,
  input  logic [WIN_BITS-1:0] offset_i,
  input  logic                en_i,
  input  logic [LAT_W-1:0]    lat_i,
  input  logic [DW-1:0]       flash_data_i,
  output logic                ack_o,
  output logic                err_o,
  output logic [DW-1:0]       rdata_o,
  output logic                flash_oe_o,
  output logic [WIN_BITS-1:0] flash_addr_o
);
  brc_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                err_q;
  logic [DW-1:0]       data_q;
  logic [WIN_BITS-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i && hit_i) begin
          addr_q <= offset_i;
          if (en_i) begin
            cnt_q   <= lat_cycles(lat_i);
            err_q   <= 1'b0;
            state_q <= ST_BUSY;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end
        end
        ST_BUSY: begin
          if (cnt_q == CNT_W'(1)) begin
            data_q  <= flash_data_i;
            state_q <= ST_RESP;
          end
          cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign flash_oe_o   = (state_q == ST_BUSY);
  assign flash_addr_o = addr_q;
  assign ack_o        = (state_q == ST_RESP);
  assign err_o        = ack_o && err_q;
  assign rdata_o      = data_q;
endmodule

// File: rtl/boot_rom_ctrl.sv
module boot_rom_ctrl
  import brc_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   DW       = 16,
  parameter int unsigned   WIN_BITS = 24,
  parameter int unsigned   MAP_BITS = 20,
  parameter logic [AW-1:0] WIN_BASE = 32'hFD00_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [AW-1:0]       addr_i,
  output logic                ack_o,
  output logic                err_o,
  output logic [DW-1:0]       rdata_o,
  input  logic                cfg_we_i,
  input  logic                cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  output logic [WIN_BITS-1:0] flash_addr_o,
  output logic                flash_oe_o,
  input  logic [DW-1:0]       flash_data_i
);
  logic             en, remap, hit;
  logic [LAT_W-1:0] lat;
  logic [WIN_BITS-1:0] offset;

  brc_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .en_o    (en),
    .lat_o   (lat),
    .remap_o (remap)
  );

  brc_decode #(
    .AW(AW), .WIN_BITS(WIN_BITS), .MAP_BITS(MAP_BITS), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr_i   (addr_i),
    .remap_i  (remap),
    .hit_o    (hit),
    .offset_o (offset)
  );

  brc_seq #(.WIN_BITS(WIN_BITS), .DW(DW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .hit_i        (hit),
    .offset_i     (offset),
    .en_i         (en),
    .lat_i        (lat),
    .flash_data_i (flash_data_i),
    .ack_o        (ack_o),
    .err_o        (err_o),
    .rdata_o      (rdata_o),
    .flash_oe_o   (flash_oe_o),
    .flash_addr_o (flash_addr_o)
  );
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int unsigned WIN_BITS = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ack_o,
  input logic                err_o,
  input logic                flash_oe_o,
  input logic [WIN_BITS-1:0] flash_addr_o
);
  logic [3:0] oe_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         oe_run <= '0;
    else if (flash_oe_o) oe_run <= oe_run + 4'd1;
    else                 oe_run <= '0;
  end

  assert_ack_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_err_with_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ack_o && !flash_oe_o));

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_oe_o && $past(flash_oe_o)) |-> $stable(flash_addr_o));

  assert_oe_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_run <= 4'd8);

  assert_ack_after_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !err_o) |-> $past(flash_oe_o));

  assert_no_oe_at_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !flash_oe_o);
endmodule

bind boot_rom_ctrl brc_checker #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_o        (ack_o),
  .err_o        (err_o),
  .flash_oe_o   (flash_oe_o),
  .flash_addr_o (flash_addr_o)
);

// File: tb/boot_rom_ctrl_tb.sv
module boot_rom_ctrl_tb;
  typedef struct packed {
    logic [7:0]  fcfg;
    logic        remap;
    logic [31:0] addr;
    logic        claim;
    logic        err;
    logic [3:0]  lat;
    logic [23:0] faddr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h80, 1'b1, 32'hFD00_0010, 1'b1, 1'b0, 4'd8, 24'h000010}, // R7 R3
    '{8'h81, 1'b1, 32'hFD12_3456, 1'b1, 1'b0, 4'd1, 24'h123456}, // R6
    '{8'h83, 1'b1, 32'hFDFF_FFFE, 1'b1, 1'b0, 4'd3, 24'hFFFFFE}, // R6 R3
    '{8'h87, 1'b1, 32'hFD80_0000, 1'b1, 1'b0, 4'd7, 24'h800000}, // R6
    '{8'h85, 1'b1, 32'h000A_BCDE, 1'b1, 1'b0, 4'd5, 24'h0ABCDE}, // R4
    '{8'h82, 1'b1, 32'h000F_FFFF, 1'b1, 1'b0, 4'd2, 24'h0FFFFF}, // R4
    '{8'h82, 1'b1, 32'h0010_0000, 1'b0, 1'b0, 4'd0, 24'h000000}, // R10
    '{8'h82, 1'b0, 32'h0000_1234, 1'b0, 1'b0, 4'd0, 24'h000000}, // R5
    '{8'h84, 1'b0, 32'hFD00_0100, 1'b1, 1'b0, 4'd4, 24'h000100}, // R3
    '{8'h03, 1'b1, 32'hFD00_0200, 1'b1, 1'b1, 4'd0, 24'h000200}, // R8
    '{8'h00, 1'b1, 32'h0000_0040, 1'b1, 1'b1, 4'd0, 24'h000040}, // R8
    '{8'h86, 1'b1, 32'hFE00_0000, 1'b0, 1'b0, 4'd0, 24'h000000}, // R10
    '{8'h82, 1'b1, 32'hFCFF_FFFF, 1'b0, 1'b0, 4'd0, 24'h000000}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        ack, err;
  logic [15:0] rdata;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [23:0] flash_addr;
  logic        flash_oe;
  logic [15:0] flash_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  assign flash_data = flash_addr[15:0] ^ {flash_addr[23:16], flash_addr[23:16]} ^ 16'h5A3C;

  boot_rom_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .ack_o(ack), .err_o(err), .rdata_o(rdata),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .flash_addr_o(flash_addr), .flash_oe_o(flash_oe),
    .flash_data_i(flash_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic access(input logic [31:0] a, output logic got_ack, output logic got_err,
                        output int oe_cnt, output logic [23:0] fa, output logic [15:0] rd,
                        output logic [15:0] last_fd);
    got_ack = 1'b0; got_err = 1'b0; oe_cnt = 0; fa = '0; rd = '0; last_fd = '0;
    @(negedge clk);
    req = 1'b1; addr = a;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (flash_oe) begin
        oe_cnt++; fa = flash_addr; last_fd = flash_data;
      end
      if (ack) begin
        got_ack = 1'b1; got_err = err; rd = rdata;
        if (!flash_oe && oe_cnt == 0) fa = flash_addr;
        break;
      end
    end
    req = 1'b0;
    @(negedge clk);
    if (ack) check("R9 ack single pulse", 32'(ack), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rb;
    logic        a, e;
    int          n;
    logic [23:0] fa;
    logic [15:0] rd, lfd;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cfg_read(1'b0, rb); check("R1 flash cfg reset", 32'(rb), 32'h80);
    cfg_read(1'b1, rb); check("R1 remap reset", 32'(rb), 32'h02);
    check("R1 no ack at reset", 32'(ack), 32'd0);
    check("R1 no oe at reset", 32'(flash_oe), 32'd0);

    // default config: latency 0 -> 8 cycles from reset state
    access(32'hFD00_0002, a, e, n, fa, rd, lfd);
    check("R7 reset latency", 32'(n), 32'd8);

    for (int i = 0; i < NV; i++) begin
      cfg_write(1'b0, VECS[i].fcfg);
      cfg_write(1'b1, {6'b0, VECS[i].remap, 1'b0});
      access(VECS[i].addr, a, e, n, fa, rd, lfd);
      if (!VECS[i].claim) begin
        check("R5/R10 unclaimed ack", 32'(a), 32'd0);
        check("R5/R10 unclaimed oe", 32'(n), 32'd0);
      end else begin
        check("R8/R9 ack", 32'(a), 32'd1);
        check("R8 err", 32'(e), 32'(VECS[i].err));
        check("R6/R7 latency", 32'(n), 32'(VECS[i].lat));
        if (!VECS[i].err) begin
          check("R3/R4 flash addr", 32'(fa), 32'(VECS[i].faddr));
          check("R9 rdata", 32'(rd), 32'(lfd));
        end
      end
    end

    // R2 reserved bits
    cfg_write(1'b0, 8'hFF);
    cfg_read(1'b0, rb); check("R2 flash cfg mask", 32'(rb), 32'h87);
    cfg_write(1'b1, 8'hFD);
    cfg_read(1'b1, rb); check("R2 remap clear", 32'(rb), 32'h00);
    cfg_write(1'b1, 8'hFF);
    cfg_read(1'b1, rb); check("R2 remap mask", 32'(rb), 32'h02);

    // R4 remap re-enabled after clear: low address answered again, latency 7
    access(32'h0000_0008, a, e, n, fa, rd, lfd);
    check("R4 remap ack", 32'(a), 32'd1);
    check("R4 remap offset", 32'(fa), 32'h000008);
    check("R6 latency 7", 32'(n), 32'd7);

    // asynchronous reset mid-access restores defaults
    @(negedge clk); req = 1'b1; addr = 32'hFD00_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b0; req = 1'b0;
    @(negedge clk);
    check("R1 oe cleared by reset", 32'(flash_oe), 32'd0);
    rst_n = 1'b1;
    cfg_read(1'b0, rb); check("R1 flash cfg after reset", 32'(rb), 32'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule